// File: doc/BRIEF.md
# Segment Translation Cache

This block performs delayed address translation for accesses that missed the last-level cache and that are not synonyms. Each segment descriptor has three values: a base, a limit and an offset. Together they map one contiguous virtual region of any size onto physical memory. The block keeps a fully associative store of recently used descriptors. When a request arrives, the virtual address is compared against the range of every valid entry. On a hit, the physical address is the virtual address plus the offset of the matching entry.

On a miss the block sends one request to an external index walker. The walker searches a tree and returns a segment-table index, or reports that no segment matches. The block then reads that descriptor from its own on-chip segment table. If the descriptor covers the address, the block installs it in the store with round-robin replacement and answers with the translated address. In every other case it answers with a translation fault. Only one request is in flight at a time. A flush input invalidates every cached entry. A write port fills the segment table.

Top module: `seg_xlate_cache`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `resp_valid` and `walk_req_valid` are 0. No store entry is valid, so the first request always goes to the walker.
- R2: A cached entry hits when it is valid and base <= VA < limit. On a hit, `resp_valid` rises two clock edges after the accepting edge, with `resp_hit`=1, `resp_fault`=0, `resp_pa`=VA+offset, and no walker request is issued.
- R3: The range check includes the base and excludes the limit. An address equal to a cached limit does not hit that entry, even when another segment begins at that address.
- R4: On a miss, exactly one single-cycle `walk_req_valid` pulse is issued, carrying the request VA, two edges after the accepting edge.
- R5: When the walker returns found=1 with an index, the table descriptor at that index is read. If it covers the VA, the response arrives two edges after the walker response with `resp_hit`=0 and `resp_pa`=VA+offset, and the descriptor is installed so that later requests in its range hit.
- R6: When the walker returns found=0, the response (`resp_fault`=1, `resp_hit`=0) arrives one edge after the walker response, and nothing is installed.
- R7: If the descriptor read by index does not cover the VA, the response is a fault and the descriptor is not installed.
- R8: Installs go to store slots in round-robin order and wrap after ENTRIES installs. After ENTRIES+1 distinct fills, the oldest fill misses and the second oldest still hits.
- R9: A one-cycle `flush` pulse invalidates every store entry, so a previously cached segment misses on its next access.
- R10: From accept until the response cycle, `req_ready` is 0, and `req_valid` raised in that window is ignored (no extra response). `resp_valid` is a single-cycle pulse.
- R11: A write on the table port replaces the descriptor at `tbl_wr_idx`, and later fills from that index use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached descriptors |
| req_valid | input | 1 | Translation request |
| req_va | input | ADDR_W | Request virtual address |
| req_ready | output | 1 | Block idle, request accepted at this edge |
| resp_valid | output | 1 | Response pulse |
| resp_pa | output | ADDR_W | Physical address (0 on fault) |
| resp_hit | output | 1 | Response came from the descriptor store |
| resp_fault | output | 1 | Translation fault |
| walk_req_valid | output | 1 | Index walker request pulse |
| walk_req_va | output | ADDR_W | Address for the walker |
| walk_resp_valid | input | 1 | Walker answer |
| walk_resp_found | input | 1 | Walker found a segment |
| walk_resp_idx | input | IDX_W | Segment-table index from the walker |
| tbl_wr_en | input | 1 | Segment table write |
| tbl_wr_idx | input | IDX_W | Segment table write index |
| tbl_wr_base | input | ADDR_W | Descriptor base |
| tbl_wr_limit | input | ADDR_W | Descriptor limit (exclusive) |
| tbl_wr_offset | input | ADDR_W | Descriptor offset |

## Verification
The hardest case to reach is replacement wrap-around. It is only visible after more distinct fills than the store has entries. It also depends on the replacement pointer, which neither flush nor a fault moves. The stimulus therefore walks ENTRIES+1 separate segments through the miss path. A bench-side model of the pointer follows every earlier install, and the stimulus then probes the oldest and second-oldest segments. A second hard case is a walker index whose descriptor does not cover the address. The bench walker model is told to return a wrong index, and a later access to the same range confirms that the wrong descriptor was not installed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WALK,
    ST_TREAD
  } xl_state_e;
endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] look_va,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_offset,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_base,
  input  logic [ADDR_W-1:0] fill_limit,
  input  logic [ADDR_W-1:0] fill_offset
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ADDR_W-1:0] base_q  [ENTRIES];
  logic [ADDR_W-1:0] limit_q [ENTRIES];
  logic [ADDR_W-1:0] off_q   [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [PW-1:0]      rr_q;
  logic               do_fill;

  assign do_fill = fill_en && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (look_va >= base_q[g]) && (look_va < limit_q[g]);

    always_ff @(posedge clk) begin
      if (do_fill && (rr_q == PW'(g))) begin
        base_q[g]  <= fill_base;
        limit_q[g] <= fill_limit;
        off_q[g]   <= fill_offset;
      end
    end
  end

  // lowest matching slot wins
  always_comb begin
    hit        = |match;
    hit_offset = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_offset = off_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (do_fill) begin
      vld_q[rr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (do_fill) begin
      rr_q <= (rr_q == PW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/seg_table_mem.sv
module seg_table_mem #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 2048
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [ADDR_W-1:0]        wr_base,
  input  logic [ADDR_W-1:0]        wr_limit,
  input  logic [ADDR_W-1:0]        wr_offset,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [ADDR_W-1:0]        rd_base,
  output logic [ADDR_W-1:0]        rd_limit,
  output logic [ADDR_W-1:0]        rd_offset
);
  localparam int WORD_W = 3 * ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_base, wr_limit, wr_offset};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_base   = rd_q[WORD_W-1 -: ADDR_W];
  assign rd_limit  = rd_q[2*ADDR_W-1 -: ADDR_W];
  assign rd_offset = rd_q[ADDR_W-1:0];
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_pa,
  output logic              resp_hit,
  output logic              resp_fault,
  output logic              walk_req_valid,
  output logic [ADDR_W-1:0] walk_req_va,
  input  logic              walk_resp_valid,
  input  logic              walk_resp_found,
  input  logic [IDX_W-1:0]  walk_resp_idx,
  output logic [ADDR_W-1:0] look_va,
  input  logic              st_hit,
  input  logic [ADDR_W-1:0] st_offset,
  output logic              tbl_rd_en,
  output logic [IDX_W-1:0]  tbl_rd_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_limit,
  input  logic [ADDR_W-1:0] tbl_offset,
  output logic              fill_en
);
  xl_state_e         state_q;
  logic [ADDR_W-1:0] va_q;
  logic              covers;

  assign req_ready   = (state_q == ST_IDLE);
  assign look_va     = va_q;
  assign walk_req_va = va_q;
  assign covers      = (va_q >= tbl_base) && (va_q < tbl_limit);
  assign tbl_rd_en   = (state_q == ST_WALK) && walk_resp_valid && walk_resp_found;
  assign tbl_rd_idx  = walk_resp_idx;
  assign fill_en     = (state_q == ST_TREAD) && covers;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      va_q           <= '0;
      resp_valid     <= 1'b0;
      resp_pa        <= '0;
      resp_hit       <= 1'b0;
      resp_fault     <= 1'b0;
      walk_req_valid <= 1'b0;
    end else begin
      resp_valid     <= 1'b0;
      resp_hit       <= 1'b0;
      resp_fault     <= 1'b0;
      walk_req_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (st_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_pa    <= va_q + st_offset;
            state_q    <= ST_IDLE;
          end else begin
            walk_req_valid <= 1'b1;
            state_q        <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_resp_valid) begin
            if (walk_resp_found) begin
              state_q <= ST_TREAD;
            end else begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_pa    <= '0;
              state_q    <= ST_IDLE;
            end
          end
        end
        default: begin
          resp_valid <= 1'b1;
          resp_fault <= !covers;
          resp_pa    <= covers ? (va_q + tbl_offset) : '0;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_cache.sv
module seg_xlate_cache #(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 128,
  parameter int TBL_DEPTH = 2048,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_pa,
  output logic              resp_hit,
  output logic              resp_fault,
  output logic              walk_req_valid,
  output logic [ADDR_W-1:0] walk_req_va,
  input  logic              walk_resp_valid,
  input  logic              walk_resp_found,
  input  logic [IDX_W-1:0]  walk_resp_idx,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [ADDR_W-1:0] tbl_wr_base,
  input  logic [ADDR_W-1:0] tbl_wr_limit,
  input  logic [ADDR_W-1:0] tbl_wr_offset
);
  logic [ADDR_W-1:0] look_va;
  logic              st_hit;
  logic [ADDR_W-1:0] st_offset;
  logic              tbl_rd_en;
  logic [IDX_W-1:0]  tbl_rd_idx;
  logic [ADDR_W-1:0] tbl_base, tbl_limit, tbl_offset;
  logic              fill_en;

  seg_xlate_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_ctrl (
    .clk, .rst,
    .req_valid, .req_va, .req_ready,
    .resp_valid, .resp_pa, .resp_hit, .resp_fault,
    .walk_req_valid, .walk_req_va,
    .walk_resp_valid, .walk_resp_found, .walk_resp_idx,
    .look_va, .st_hit, .st_offset,
    .tbl_rd_en, .tbl_rd_idx, .tbl_base, .tbl_limit, .tbl_offset,
    .fill_en
  );

  seg_desc_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_store (
    .clk, .rst, .flush,
    .look_va, .hit(st_hit), .hit_offset(st_offset),
    .fill_en, .fill_base(tbl_base), .fill_limit(tbl_limit), .fill_offset(tbl_offset)
  );

  seg_table_mem #(.ADDR_W(ADDR_W), .DEPTH(TBL_DEPTH)) i_table (
    .clk,
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
    .wr_base(tbl_wr_base), .wr_limit(tbl_wr_limit), .wr_offset(tbl_wr_offset),
    .rd_en(tbl_rd_en), .rd_idx(tbl_rd_idx),
    .rd_base(tbl_base), .rd_limit(tbl_limit), .rd_offset(tbl_offset)
  );
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_fault,
  input logic walk_req_valid
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !resp_valid && !walk_req_valid));

  assert_hit_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> $past(req_valid && req_ready, 2));

  assert_walk_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |=> !walk_req_valid);

  assert_walk_timing_R4: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> $past(req_valid && req_ready, 2));

  assert_fault_shape_R6: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> (resp_valid && !resp_hit));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
endmodule

bind seg_xlate_cache seg_xlate_checker i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
  .walk_req_valid(walk_req_valid)
);

// File: tb/test_seg_xlate_cache.sv
module test_seg_xlate_cache;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int ENTRIES    = 128;
  localparam int TBL_DEPTH  = 2048;
  localparam int IDX_W      = $clog2(TBL_DEPTH);
  localparam int NSEG       = 256;

  logic clk = 0, rst = 1, flush = 0;
  logic req_valid = 0;
  logic [ADDR_W-1:0] req_va = '0;
  logic req_ready, resp_valid, resp_hit, resp_fault, walk_req_valid;
  logic [ADDR_W-1:0] resp_pa, walk_req_va;
  logic walk_resp_valid = 0, walk_resp_found = 0;
  logic [IDX_W-1:0] walk_resp_idx = '0;
  logic tbl_wr_en = 0;
  logic [IDX_W-1:0] tbl_wr_idx = '0;
  logic [ADDR_W-1:0] tbl_wr_base = '0, tbl_wr_limit = '0, tbl_wr_offset = '0;

  seg_xlate_cache #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TBL_DEPTH(TBL_DEPTH)) i_seg_xlate_cache (
    .clk, .rst, .flush, .req_valid, .req_va, .req_ready,
    .resp_valid, .resp_pa, .resp_hit, .resp_fault,
    .walk_req_valid, .walk_req_va, .walk_resp_valid, .walk_resp_found, .walk_resp_idx,
    .tbl_wr_en, .tbl_wr_idx, .tbl_wr_base, .tbl_wr_limit, .tbl_wr_offset
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  // bench copy of table contents and of the cache state
  logic [ADDR_W-1:0] tb_b [NSEG], tb_l [NSEG], tb_o [NSEG];
  logic [ADDR_W-1:0] mb [ENTRIES], ml [ENTRIES], mo [ENTRIES];
  logic [ENTRIES-1:0] mv = '0;
  int mptr = 0;
  int force_idx = -1;
  int walk_cnt = 0;
  logic wk_found = 0;
  int wk_idx = 0;
  logic [ADDR_W-1:0] cur_va = '0;
  logic q_hit [$], q_fault [$];
  logic [ADDR_W-1:0] q_pa [$];
  string q_tag [$];

  task automatic chk(input logic ok, input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int model_find(input logic [ADDR_W-1:0] va);
    for (int i = 0; i < ENTRIES; i++)
      if (mv[i] && va >= mb[i] && va < ml[i]) return i;
    return -1;
  endfunction

  function automatic int tree_find(input logic [ADDR_W-1:0] va);
    for (int i = 0; i < NSEG; i++)
      if (tb_l[i] > tb_b[i] && va >= tb_b[i] && va < tb_l[i]) return i;
    return -1;
  endfunction

  task automatic tbl_write(input int idx, input logic [ADDR_W-1:0] b, l, o);
    tbl_wr_en = 1; tbl_wr_idx = IDX_W'(idx);
    tbl_wr_base = b; tbl_wr_limit = l; tbl_wr_offset = o;
    tb_b[idx] = b; tb_l[idx] = l; tb_o[idx] = o;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic do_flush();
    flush = 1;
    @(negedge clk);
    flush = 0;
    mv = '0;
  endtask

  task automatic send(input logic [ADDR_W-1:0] va, input string tag, input logic busy_poke);
    int mi, ti, w0;
    logic eh, ef;
    logic [ADDR_W-1:0] ep;
    mi = model_find(va);
    eh = 0; ef = 0; ep = '0;
    if (mi >= 0) begin
      eh = 1; ep = va + mo[mi];
    end else begin
      ti = (force_idx >= 0) ? force_idx : tree_find(va);
      wk_found = (ti >= 0);
      wk_idx = (ti >= 0) ? ti : 0;
      if (ti < 0) ef = 1;
      else if (va >= tb_b[ti] && va < tb_l[ti]) begin
        ep = va + tb_o[ti];
        mb[mptr] = tb_b[ti]; ml[mptr] = tb_l[ti]; mo[mptr] = tb_o[ti];
        mv[mptr] = 1'b1;
        mptr = (mptr + 1) % ENTRIES;
      end else ef = 1;
    end
    q_hit.push_back(eh); q_fault.push_back(ef); q_pa.push_back(ep); q_tag.push_back(tag);
    cur_va = va;
    w0 = walk_cnt;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_va = va;
    @(negedge clk);
    chk(!req_ready, {tag, " R10 ready low after accept"}, ADDR_W'(req_ready), '0);
    if (busy_poke) begin
      req_va = va ^ 32'h0000_0040;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 0;
    if (eh && !busy_poke) begin
      @(negedge clk);
      chk(resp_valid, {tag, " R2 hit latency"}, ADDR_W'(resp_valid), 1);
    end
    while (q_hit.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk((walk_cnt - w0) == (eh ? 0 : 1), {tag, eh ? " R2 no walk on hit" : " R4 one walk on miss"},
        ADDR_W'(walk_cnt - w0), eh ? 0 : 1);
  endtask

  // walker model and R5/R6 latency checks
  initial begin
    forever begin
      @(negedge clk);
      if (walk_req_valid) begin
        walk_cnt++;
        chk(walk_req_va == cur_va, "R4 walk address", walk_req_va, cur_va);
        @(negedge clk);
        @(negedge clk);
        walk_resp_valid = 1; walk_resp_found = wk_found; walk_resp_idx = IDX_W'(wk_idx);
        @(negedge clk);
        walk_resp_valid = 0;
        if (!wk_found) chk(resp_valid, "R6 fault latency", ADDR_W'(resp_valid), 1);
        @(negedge clk);
        if (wk_found) chk(resp_valid, "R5 fill latency", ADDR_W'(resp_valid), 1);
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && resp_valid) begin
        if (q_hit.size() == 0) begin
          chk(0, "R10 unexpected response", resp_pa, '0);
        end else begin
          logic eh, ef;
          logic [ADDR_W-1:0] ep;
          string tg;
          eh = q_hit.pop_front(); ef = q_fault.pop_front();
          ep = q_pa.pop_front(); tg = q_tag.pop_front();
          chk(resp_hit == eh, {tg, " hit flag"}, ADDR_W'(resp_hit), ADDR_W'(eh));
          chk(resp_fault == ef, {tg, " fault flag"}, ADDR_W'(resp_fault), ADDR_W'(ef));
          if (!ef) chk(resp_pa == ep, {tg, " physical address"}, resp_pa, ep);
        end
      end
    end
  end

  logic done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      tb_b[i] = '0; tb_l[i] = '0; tb_o[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", ADDR_W'(req_ready), 1);
    chk(!resp_valid && !walk_req_valid, "R1 outputs idle", ADDR_W'({resp_valid, walk_req_valid}), 0);

    for (int i = 0; i < 200; i++)
      tbl_write(i, 32'h1000_0000 + i * 32'h1_0000,
                32'h1000_0000 + i * 32'h1_0000 + 32'h8000 + i * 16,
                32'h4000_0000 + i * 32'h100);
    tbl_write(200, 32'h3000_0000, 32'h3000_1000, 32'h0100_0000);
    tbl_write(201, 32'h3000_1000, 32'h3000_2000, 32'h0200_0000);

    send(32'h1000_0123, "R1 R5 first access misses", 0);
    send(32'h1000_0456, "R2 hit in seg0", 0);
    send(32'h1000_0000, "R3 base inclusive", 0);
    send(32'h1000_7FFF, "R3 last byte", 0);
    send(32'h1000_8000, "R3 R6 limit in gap faults", 0);
    send(32'h1000_FFFF, "R6 gap before seg1", 0);
    send(32'h3000_0800, "R5 fill seg200", 0);
    send(32'h3000_1000, "R3 adjacent limit goes to next segment", 0);
    send(32'h3000_1004, "R2 hit seg201", 0);

    force_idx = 5;
    send(32'h1007_0010, "R7 wrong index faults", 0);
    force_idx = -1;
    send(32'h1007_0020, "R7 not installed", 0);

    do_flush();
    send(32'h1000_0200, "R9 miss after flush", 0);
    send(32'h1000_0204, "R9 refilled", 0);

    tbl_write(3, 32'h1003_0000, 32'h1003_8000, 32'h5555_0000);
    do_flush();
    send(32'h1003_0010, "R11 new table contents", 0);

    send(32'h1004_0010, "R10 busy request ignored", 1);

    do_flush();
    for (int s = 10; s < 10 + ENTRIES + 1; s++)
      send(32'h1000_0000 + s * 32'h1_0000 + 32'h10, "R8 fill", 0);
    send(32'h1000_0000 + 11 * 32'h1_0000 + 32'h20, "R8 second oldest hits", 0);
    send(32'h1000_0000 + 10 * 32'h1_0000 + 32'h20, "R8 oldest evicted", 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule